// File: doc/BRIEF.md
# Banked Memory Address Mapper

This block turns four 5-bit bank-control registers, a processor address and a video address into physical addresses for a banked program store and a banked character store. Program memory is divided into 16 KB pages and character memory into 4 KB pages. The block also emits a nametable mirroring code and a work-RAM enable.

The program side works as one 32 KB window or as two 16 KB slots. In the two-slot mode, one slot is fixed and the other follows the page register. Bit 4 of the first character register adds a 16-page (256 KB) offset to every program page, which lets the program store grow past 256 KB. The character side works as one 8 KB window or as two independent 4 KB windows.

The block is pure decoding. The registers are loaded elsewhere. Page numbers wrap modulo the installed page count, set by the page-width parameters. With `REG_OUT` = 1 (the default), every output is registered and shows its inputs one clock later. With `REG_OUT` = 0, the outputs are combinational.

Top module: `banked_mapper`

## Requirements
- R1: `mirror_sel` equals control bits 1:0 of `ctl_mode`, encoded as 0 = single screen A, 1 = single screen B, 2 = vertical, 3 = horizontal.
- R2: When `ctl_mode[3]` = 0 (32 KB mode), the program page is (`ctl_prg[3:0]` + offset + `cpu_addr[14]`).
- R3: When `ctl_mode[3:2]` = 2'b11, the low slot (`cpu_addr[14]` = 0) maps page (`ctl_prg[3:0]` + offset) and the high slot maps page (15 + offset).
- R4: When `ctl_mode[3:2]` = 2'b10, the low slot maps page (offset) and the high slot maps page (`ctl_prg[3:0]` + offset).
- R5: The offset is 16 when `ctl_chr_lo[4]` = 1 and 0 otherwise. Page sums wrap modulo 2^`PRG_PAGE_W`; for example, in 32 KB mode with page register 15 and offset 16, the upper half maps page 0 when `PRG_PAGE_W` = 5.
- R6: When `ctl_mode[4]` = 1 (4 KB character mode), the character page is `ctl_chr_lo` for `ppu_addr[12]` = 0 and `ctl_chr_hi` for `ppu_addr[12]` = 1.
- R7: When `ctl_mode[4]` = 0 (8 KB character mode), the character page is {`ctl_chr_lo[4:1]`, `ppu_addr[12]`}. In this mode `ctl_chr_lo[0]` and `ctl_chr_hi` have no effect.
- R8: `wram_en` is the inverse of `ctl_prg[4]`.
- R9: `prg_addr` = {page, `cpu_addr[13:0]`} and `chr_addr` = {page, `ppu_addr[11:0]`}.
- R10: With `REG_OUT` = 1, outputs change only on the rising clock edge after their inputs change, and reset drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registered outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_mode | input | 5 | Mode register: mirroring, program mode, character mode |
| ctl_chr_lo | input | 5 | Low character page; bit 4 is the program offset |
| ctl_chr_hi | input | 5 | High character page (4 KB mode) |
| ctl_prg | input | 5 | Program page in bits 3:0; bit 4 disables work RAM |
| cpu_addr | input | 15 | Processor address within the program window |
| ppu_addr | input | 13 | Video address within the character window |
| prg_addr | output | PRG_PAGE_W+14 | Physical program address |
| chr_addr | output | CHR_PAGE_W+12 | Physical character address |
| mirror_sel | output | 2 | Mirroring code |
| wram_en | output | 1 | Work-RAM enable |

## Verification
The hardest case to reach is the wrap of a page sum past the installed page count. This needs the offset bit set, page register 15, 32 KB mode and the upper half, all at once. A full sweep of every mode register value against every page register value reaches it, along with four character-register patterns that each toggle the offset bit. Each combination is applied with all four slot/half address pairings. A directed case also checks that the registered outputs hold until the clock edge.

// File: rtl/banked_mapper.sv
module banked_mapper #(
  parameter int PRG_PAGE_W = 5,
  parameter int CHR_PAGE_W = 5,
  parameter bit REG_OUT    = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [4:0]                 ctl_mode,
  input  logic [4:0]                 ctl_chr_lo,
  input  logic [4:0]                 ctl_chr_hi,
  input  logic [4:0]                 ctl_prg,
  input  logic [14:0]                cpu_addr,
  input  logic [12:0]                ppu_addr,
  output logic [PRG_PAGE_W+13:0]     prg_addr,
  output logic [CHR_PAGE_W+11:0]     chr_addr,
  output logic [1:0]                 mirror_sel,
  output logic                       wram_en
);
  localparam int PRG_AW = PRG_PAGE_W + 14;
  localparam int CHR_AW = CHR_PAGE_W + 12;

  logic [5:0] prg_off, prg_sw, prg_page;
  logic [4:0] chr_page;
  logic [PRG_AW-1:0] prg_nx;
  logic [CHR_AW-1:0] chr_nx;
  logic unused_prg_top;

  assign prg_off = {1'b0, ctl_chr_lo[4], 4'b0000};
  assign prg_sw  = {2'b00, ctl_prg[3:0]} + prg_off;

  always_comb begin
    if (!ctl_mode[3])
      prg_page = prg_sw + {5'b0, cpu_addr[14]};
    else if (ctl_mode[2])
      prg_page = cpu_addr[14] ? prg_off + 6'd15 : prg_sw;
    else
      prg_page = cpu_addr[14] ? prg_sw : prg_off;
  end

  assign chr_page = ctl_mode[4] ? (ppu_addr[12] ? ctl_chr_hi : ctl_chr_lo)
                                : {ctl_chr_lo[4:1], ppu_addr[12]};

  assign prg_nx = {prg_page[PRG_PAGE_W-1:0], cpu_addr[13:0]};
  assign chr_nx = {chr_page[CHR_PAGE_W-1:0], ppu_addr[11:0]};
  assign unused_prg_top = ^prg_page;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prg_addr   <= '0;
          chr_addr   <= '0;
          mirror_sel <= 2'b00;
          wram_en    <= 1'b0;
        end else begin
          prg_addr   <= prg_nx;
          chr_addr   <= chr_nx;
          mirror_sel <= ctl_mode[1:0];
          wram_en    <= ~ctl_prg[4];
        end
      end

      // R9
      offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> prg_addr[13:0] == $past(cpu_addr[13:0]));

      // R7
      chr_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ctl_mode[4])) |-> chr_addr[12] == $past(ppu_addr[12]));

      // R8
      wram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> wram_en != $past(ctl_prg[4]));

      // R3
      fixed_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctl_mode[3:2]) == 2'b11 && $past(cpu_addr[14]))
          |-> prg_addr[17:14] == 4'hF);

      // R4
      fixed_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctl_mode[3:2]) == 2'b10 && !$past(cpu_addr[14]))
          |-> prg_addr[17:14] == 4'h0);

      // R1
      mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> mirror_sel == $past(ctl_mode[1:0]));
    end else begin : g_comb
      assign prg_addr   = prg_nx;
      assign chr_addr   = chr_nx;
      assign mirror_sel = ctl_mode[1:0];
      assign wram_en    = ~ctl_prg[4];
    end
  endgenerate
endmodule

// File: tb/test_banked_mapper.sv
`timescale 1ns/1ps
module test_banked_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ctl_mode = '0, ctl_chr_lo = '0, ctl_chr_hi = '0, ctl_prg = '0;
  logic [14:0] cpu_addr = '0;
  logic [12:0] ppu_addr = '0;
  logic [18:0] prg_addr;
  logic [16:0] chr_addr;
  logic [1:0]  mirror_sel;
  logic        wram_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  banked_mapper i_banked_mapper (
    .clk(clk), .rst_n(rst_n), .ctl_mode(ctl_mode), .ctl_chr_lo(ctl_chr_lo),
    .ctl_chr_hi(ctl_chr_hi), .ctl_prg(ctl_prg), .cpu_addr(cpu_addr),
    .ppu_addr(ppu_addr), .prg_addr(prg_addr), .chr_addr(chr_addr),
    .mirror_sel(mirror_sel), .wram_en(wram_en));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_prg_page(int m, int lo, int pr, int a14);
    int off = ((lo / 16) % 2) * 16;
    int p = pr % 16;
    int pg;
    if (((m / 8) % 2) == 0) pg = p + off + a14;
    else if (((m / 4) % 2) == 1) pg = a14 ? 15 + off : p + off;
    else pg = a14 ? p + off : off;
    return pg % 32;
  endfunction

  function automatic int exp_chr_page(int m, int lo, int hi, int a12);
    if (((m / 16) % 2) == 1) return a12 ? hi : lo;
    return (lo - (lo % 2)) + a12;
  endfunction

  function automatic string prg_tag(int m, int lo);
    if (((lo / 16) % 2) == 1) return "R5";
    if (((m / 8) % 2) == 0) return "R2";
    if (((m / 4) % 2) == 1) return "R3";
    return "R4";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lo_set[4] = '{0, 16, 11, 31};
    int idx = 0;
    ctl_mode = 5'h1F; ctl_prg = 5'h0F; cpu_addr = 15'h7FFF; ppu_addr = 13'h1FFF;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", prg_addr, 0);
    check("R10", chr_addr, 0);
    check("R10", mirror_sel, 0);
    check("R10", wram_en, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 latency: outputs hold until the next edge
    ctl_mode = 5'b01100; ctl_chr_lo = 5'h00; ctl_prg = 5'h03; cpu_addr = 15'h0123;
    @(negedge clk);
    ctl_prg = 5'h05; cpu_addr = 15'h0456; ctl_mode = 5'b01111;
    #1;
    check("R10", prg_addr, 3 * 16384 + 'h123);
    check("R10", mirror_sel, 0);
    @(negedge clk);
    check("R10", prg_addr, 5 * 16384 + 'h456);
    check("R10", mirror_sel, 3);

    // R5 wrap: 32 KB mode, page 15, offset 16, upper half -> page 0
    ctl_mode = 5'b00000; ctl_chr_lo = 5'h10; ctl_prg = 5'h0F; cpu_addr = 15'h4ABC;
    @(negedge clk);
    check("R5", prg_addr, 'h0ABC);

    // R7 ignored inputs in 8 KB mode: bit 0 of low register and high register
    ctl_mode = 5'b00000; ctl_chr_lo = 5'h07; ctl_chr_hi = 5'h1A; ppu_addr = 13'h1234;
    @(negedge clk);
    check("R7", chr_addr, 7 * 4096 + 'h234);
    ctl_chr_lo = 5'h06; ctl_chr_hi = 5'h03;
    @(negedge clk);
    check("R7", chr_addr, 7 * 4096 + 'h234);

    // Sweep of all mode and page register values
    for (int m = 0; m < 32; m++) begin
      for (int pr = 0; pr < 32; pr++) begin
        for (int k = 0; k < 4; k++) begin
          for (int h = 0; h < 4; h++) begin
            int lo = lo_set[k];
            int hi = pr ^ 'h15;
            int a14 = h % 2;
            int a12 = h / 2;
            int co = (idx * 977) % 16384;
            int po = (idx * 331) % 4096;
            idx++;
            ctl_mode = 5'(m); ctl_chr_lo = 5'(lo); ctl_chr_hi = 5'(hi); ctl_prg = 5'(pr);
            cpu_addr = 15'(a14 * 16384 + co);
            ppu_addr = 13'(a12 * 4096 + po);
            @(negedge clk);
            check(prg_tag(m, lo), prg_addr / 16384, exp_prg_page(m, lo, pr, a14));
            check("R9", prg_addr % 16384 + (chr_addr % 4096) * 16384, co + po * 16384);
            check(((m / 16) % 2) ? "R6" : "R7", chr_addr / 4096, exp_chr_page(m, lo, hi, a12));
            check("R1", mirror_sel, m % 4);
            check("R8", wram_en, ((pr / 16) % 2) ? 0 : 1);
          end
        end
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule